// File: doc/BRIEF.md
# Cartridge Program and Pattern Bank Mapper

This block is the bank-switching core of a game cartridge. The CPU writes bank numbers into a small set of registers through a write port that carries a 16-bit address and 8-bit data. The block then turns any CPU address in the upper 32 KB into an address in a program memory that is built from 8 KB banks. It turns any 14-bit pattern-bus address below 0x2000 into an address in a pattern memory that is built from 1 KB banks. It also drives a one-bit nametable mirroring select.

Three of the four 8 KB CPU windows can be switched independently. The top window always shows the final program bank. The pattern space has eight 1 KB windows, and each one can be switched on its own. Register decoding uses exact addresses, so writes to neighbouring addresses change nothing. Both bank counts are parameters. A bank number at or above the count wraps modulo that count when it is translated. The translated addresses are combinational from the current register contents. The registers load on the rising clock edge at which the write strobe is high.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write to 0x8000, 0x8001 or 0x8002 stores the data as the bank for the CPU window at 0x8000, 0xA000 or 0xC000 respectively; prg_addr is {bank, cpu_addr[12:0]}, where cpu_addr[14:13] picks the window.
- R2: CPU addresses 0xE000 to 0xFFFF always map to program bank PRG_BANKS-1, whatever was written.
- R3: A write to any address other than 0x8000–0x8002, 0xA000–0xA007 and 0xD000 (for example 0x8003, 0x8004, 0xA008, 0xC001, 0xD001, 0xFFFF) changes no bank register and does not change the mirroring select.
- R4: A write to 0xA000 through 0xA007 stores the data as the bank for pattern window wr_addr[2:0]; chr_addr is {bank, ppu_addr[9:0]}, where ppu_addr[12:10] picks the window.
- R5: The pattern bank placed in chr_addr is the stored number modulo CHR_BANKS.
- R6: The program bank placed in prg_addr is the stored number modulo PRG_BANKS.
- R7: A write to 0xD000 sets mirror_horiz to data bit 0, where 1 means horizontal and 0 means vertical; data bits 7:1 are ignored.
- R8: While reset is asserted, and right after it is released, the program windows hold banks 0, 1 and 2, all pattern windows hold bank 0, and mirror_horiz is 0 (vertical).
- R9: A register changes only on a rising clock edge with cpu_wr high. The translated outputs show the old bank up to that edge and the new bank right after it.
- R10: prg_cs equals cpu_addr[15], and chr_cs is high exactly when ppu_addr[13] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 16 | CPU address for register writes and for program translation |
| cpu_data | input | 8 | Write data |
| ppu_addr | input | 14 | Pattern-bus address |
| prg_addr | output | PRG_BW+13 | Translated program-memory address |
| prg_cs | output | 1 | High when the CPU address is inside the cartridge window |
| chr_addr | output | CHR_BW+10 | Translated pattern-memory address |
| chr_cs | output | 1 | High when the pattern address is inside the pattern space |
| mirror_horiz | output | 1 | Mirroring select: 1 horizontal, 0 vertical |

## Verification
The bench targets addresses that sit right beside valid registers: 0x8003, 0x8004, 0xA008, 0xD001 and 0xFFFF. A decoder that compared only the low address bits would let one of these overwrite a program bank, a pattern bank or the mirroring select, and a later probe would show the wrong bank. It writes bank numbers at and above both bank counts, which the default parameters set to non-powers of two. A design that truncated the bank number instead of wrapping it would give addresses past the end of the memory. It also probes the top window after its neighbours have been rewritten, to catch a fixed window that was wired to a register by mistake. It samples the outputs on both sides of the write edge, and it applies reset in the middle of the run. These catch a register that loads late, a register that loads without the strobe, and wrong reset values.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int PRG_WIN = 3;
  localparam int CHR_WIN = 8;

  typedef logic [7:0] bank_t;

  // bank number folded into the range 0 .. cnt-1
  function automatic bank_t fold_bank(bank_t num, int unsigned cnt);
    int unsigned t;
    t = 32'(num) % cnt;
    return bank_t'(t);
  endfunction

  // exact decode of 0x8000..0x8002
  function automatic logic is_prg_reg(logic [15:0] a);
    return (a[15:2] == 14'h2000) && (a[1:0] != 2'b11);
  endfunction

  // exact decode of 0xA000..0xA007
  function automatic logic is_chr_reg(logic [15:0] a);
    return a[15:3] == 13'h1400;
  endfunction

  function automatic logic is_mir_reg(logic [15:0] a);
    return a == 16'hD000;
  endfunction
endpackage

// File: rtl/bank_regs.sv
module bank_regs
  import cart_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output bank_t       prg_bank [PRG_WIN],
  output bank_t       chr_bank [CHR_WIN],
  output logic        mirror_h
);
  localparam int STATE_W = 8 * (PRG_WIN + CHR_WIN) + 1;

  // named decode events
  logic hit_prg, hit_chr, hit_mir, hit_other;
  assign hit_prg   = wr_en && is_prg_reg(wr_addr);
  assign hit_chr   = wr_en && is_chr_reg(wr_addr);
  assign hit_mir   = wr_en && is_mir_reg(wr_addr);
  assign hit_other = wr_en && !is_prg_reg(wr_addr) && !is_chr_reg(wr_addr) && !is_mir_reg(wr_addr);

  for (genvar g = 0; g < PRG_WIN; g++) begin : g_prg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prg_bank[g] <= bank_t'(g);
      else if (hit_prg && wr_addr[1:0] == 2'(g))
        prg_bank[g] <= wr_data;
    end
    // R1
    prg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_prg && wr_addr[1:0] == 2'(g)) |=> prg_bank[g] == $past(wr_data));
  end

  for (genvar g = 0; g < CHR_WIN; g++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chr_bank[g] <= '0;
      else if (hit_chr && wr_addr[2:0] == 3'(g))
        chr_bank[g] <= wr_data;
    end
    // R4
    chr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_chr && wr_addr[2:0] == 3'(g)) |=> chr_bank[g] == $past(wr_data));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mirror_h <= 1'b0;
    else if (hit_mir)
      mirror_h <= wr_data[0];
  end

  // flattened view of every stored bit, for the stability checks
  logic [STATE_W-1:0] state_vec;
  always_comb begin
    for (int i = 0; i < PRG_WIN; i++) state_vec[8*i +: 8] = prg_bank[i];
    for (int i = 0; i < CHR_WIN; i++) state_vec[8*(PRG_WIN+i) +: 8] = chr_bank[i];
    state_vec[STATE_W-1] = mirror_h;
  end

  // R3
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_other |=> $stable(state_vec));
  // R9
  no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_vec));
  // R7
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mir |=> mirror_h == $past(wr_data[0]));
  // R8
  reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (prg_bank[0] == 8'd0 && prg_bank[1] == 8'd1 && prg_bank[2] == 8'd2
                      && state_vec[STATE_W-1:8*PRG_WIN] == '0));
endmodule

// File: rtl/prg_xlate.sv
module prg_xlate
  import cart_map_pkg::*;
#(
  parameter int PRG_BANKS = 11,
  localparam int PRG_BW = $clog2(PRG_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  bank_t             prg_bank [PRG_WIN],
  output logic [PRG_BW+12:0] prg_addr,
  output logic              prg_cs
);
  logic [1:0] win;
  logic       fixed_win;
  bank_t      sel_bank;

  assign win       = cpu_addr[14:13];
  assign fixed_win = (win == 2'b11);

  always_comb begin
    case (win)
      2'd0:    sel_bank = prg_bank[0];
      2'd1:    sel_bank = prg_bank[1];
      2'd2:    sel_bank = prg_bank[2];
      default: sel_bank = bank_t'(PRG_BANKS - 1);
    endcase
  end

  assign prg_addr = {PRG_BW'(fold_bank(sel_bank, PRG_BANKS)), cpu_addr[12:0]};
  assign prg_cs   = cpu_addr[15];

  // R2
  last_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_win |-> prg_addr[PRG_BW+12:13] == PRG_BW'(PRG_BANKS - 1));
  // R6
  prg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(prg_addr[PRG_BW+12:13]) < PRG_BANKS);
endmodule

// File: rtl/chr_xlate.sv
module chr_xlate
  import cart_map_pkg::*;
#(
  parameter int CHR_BANKS = 13,
  localparam int CHR_BW = $clog2(CHR_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       ppu_addr,
  input  bank_t             chr_bank [CHR_WIN],
  output logic [CHR_BW+9:0] chr_addr,
  output logic              chr_cs
);
  logic [2:0] win;
  bank_t      sel_bank;

  assign win      = ppu_addr[12:10];
  assign sel_bank = chr_bank[win];
  assign chr_addr = {CHR_BW'(fold_bank(sel_bank, CHR_BANKS)), ppu_addr[9:0]};
  assign chr_cs   = !ppu_addr[13];

  // R5
  chr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(chr_addr[CHR_BW+9:10]) < CHR_BANKS);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int PRG_BANKS = 11,
  parameter int CHR_BANKS = 13,
  localparam int PRG_BW = $clog2(PRG_BANKS),
  localparam int CHR_BW = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRG_BW + 13,
  localparam int CHR_AW = CHR_BW + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic [13:0]       ppu_addr,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_cs,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_cs,
  output logic              mirror_horiz
);
  bank_t prg_bank [PRG_WIN];
  bank_t chr_bank [CHR_WIN];

  bank_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cpu_wr),
    .wr_addr  (cpu_addr),
    .wr_data  (cpu_data),
    .prg_bank (prg_bank),
    .chr_bank (chr_bank),
    .mirror_h (mirror_horiz)
  );

  prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .prg_bank (prg_bank),
    .prg_addr (prg_addr),
    .prg_cs   (prg_cs)
  );

  chr_xlate #(.CHR_BANKS(CHR_BANKS)) u_chr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ppu_addr (ppu_addr),
    .chr_bank (chr_bank),
    .chr_addr (chr_addr),
    .chr_cs   (chr_cs)
  );
endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int NP = 11;
  localparam int NC = 13;
  localparam int PAW = $clog2(NP) + 13;
  localparam int CAW = $clog2(NC) + 10;

  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [13:0] ppu_addr = '0;
  logic [PAW-1:0] prg_addr;
  logic [CAW-1:0] chr_addr;
  logic prg_cs, chr_cs, mirror_horiz;

  always #2 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(NP), .CHR_BANKS(NC)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .prg_cs(prg_cs), .chr_addr(chr_addr), .chr_cs(chr_cs),
    .mirror_horiz(mirror_horiz)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench-side model of the register state
  int m_prg [3];
  int m_chr [8];
  int m_mir;

  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic [15:0] pa;
    logic [15:0] va;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VEC [0:15] = '{
    '{16'h8000, 8'h04, 16'h8000, 16'h0000, 8'd1},
    '{16'h8001, 8'h05, 16'hA123, 16'h0400, 8'd1},
    '{16'h8002, 8'h06, 16'hDFFF, 16'h0800, 8'd1},
    '{16'h8003, 8'h00, 16'h8000, 16'h0C00, 8'd3},
    '{16'h8002, 8'h0A, 16'hE456, 16'h1000, 8'd2},
    '{16'hA000, 8'h03, 16'hC000, 16'h0000, 8'd4},
    '{16'hA007, 8'h0C, 16'hFFFF, 16'h1FFF, 8'd4},
    '{16'hA005, 8'h20, 16'h8000, 16'h1400, 8'd5},
    '{16'h8000, 8'h0D, 16'h8000, 16'h1401, 8'd6},
    '{16'hD000, 8'hFE, 16'hA000, 16'h1C00, 8'd7},
    '{16'hD000, 8'h01, 16'hA000, 16'h1C00, 8'd7},
    '{16'hA008, 8'h55, 16'h8000, 16'h0000, 8'd3},
    '{16'hD001, 8'h00, 16'hA000, 16'h0000, 8'd3},
    '{16'h8004, 8'h09, 16'h8000, 16'h0000, 8'd3},
    '{16'hC001, 8'hFF, 16'hC000, 16'h1C00, 8'd3},
    '{16'hFFFF, 8'hFF, 16'hE000, 16'h1400, 8'd3}
  };

  task automatic model_reset();
    m_prg = '{0, 1, 2};
    foreach (m_chr[i]) m_chr[i] = 0;
    m_mir = 0;
  endtask

  task automatic model_write(logic [15:0] a, logic [7:0] d);
    if (a >= 16'h8000 && a <= 16'h8002) m_prg[a[1:0]] = int'(d);
    if (a >= 16'hA000 && a <= 16'hA007) m_chr[a[2:0]] = int'(d);
    if (a == 16'hD000) m_mir = int'(d[0]);
  endtask

  function automatic int exp_prg(logic [15:0] p);
    int b;
    b = (p[15:13] == 3'b111 || p[14:13] == 2'b11) ? NP - 1 : m_prg[p[14:13]] % NP;
    return b * 8192 + int'(p[12:0]);
  endfunction

  function automatic int exp_chr(logic [13:0] v);
    return (m_chr[v[12:10]] % NC) * 1024 + int'(v[9:0]);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic probe(string req, logic [15:0] pa, logic [13:0] va);
    cpu_addr = pa;
    ppu_addr = va;
    #1;
    chk(req, "prg_addr", 32'(prg_addr), exp_prg(pa));
    chk(req, "chr_addr", 32'(chr_addr), exp_chr(va));
    chk(req, "mirror",   32'(mirror_horiz), m_mir);
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    model_write(a, d);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R8: reset state, during and after reset
    probe("R8", 16'h8000, 14'h0000);
    rst_n = 1;
    @(negedge clk);
    probe("R8", 16'hA000, 14'h1FFF);
    probe("R8", 16'hC000, 14'h0C00);
    probe("R2", 16'hE000, 14'h0400);

    // table walk
    for (int i = 0; i <= 15; i++) begin
      do_write(VEC[i].wa, VEC[i].wd);
      probe($sformatf("R%0d", VEC[i].req), VEC[i].pa, VEC[i].va[13:0]);
    end

    // R6: bank number 0xFF folds to 0xFF mod 11 = 2
    do_write(16'h8001, 8'hFF);
    probe("R6", 16'hA000, 14'h0000);
    // R5: bank 0xFF folds to 0xFF mod 13 = 8
    do_write(16'hA002, 8'hFF);
    probe("R5", 16'h8000, 14'h0800);

    // R9: strobe low leaves state, change lands on the write edge
    @(negedge clk);
    cpu_addr = 16'h8002; cpu_data = 8'h07; cpu_wr = 0;
    @(negedge clk);
    probe("R9", 16'h8002, 14'h0000);
    cpu_addr = 16'h8002; cpu_data = 8'h07; cpu_wr = 1;
    #1;
    chk("R9", "old bank before edge", 32'(prg_addr), exp_prg(16'h8002));
    @(posedge clk);
    #1;
    cpu_wr = 0;
    model_write(16'h8002, 8'h07);
    chk("R9", "new bank after edge", 32'(prg_addr), exp_prg(16'h8002));
    // R1: window 2 now bank 7 via 0xC000
    probe("R1", 16'hC000, 14'h0000);

    // R10: select outputs
    @(negedge clk);
    cpu_addr = 16'h7FFF; ppu_addr = 14'h2000; #1;
    chk("R10", "prg_cs low", 32'(prg_cs), 0);
    chk("R10", "chr_cs low", 32'(chr_cs), 0);
    cpu_addr = 16'h8000; ppu_addr = 14'h1FFF; #1;
    chk("R10", "prg_cs high", 32'(prg_cs), 1);
    chk("R10", "chr_cs high", 32'(chr_cs), 1);

    // R8: reset in the middle of the run
    @(negedge clk);
    rst_n = 0;
    model_reset();
    probe("R8", 16'hC000, 14'h1C00);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    probe("R8", 16'h8000, 14'h1400);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule